// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and tells the processor which one to serve. Every source owns an 8-bit priority level register; a level of zero turns the source off. A 64-bit mask, held as two 32-bit halves, blocks sources individually. A 64-bit force register lets software raise a source without its request line. On every clock the block picks the strongest active source and presents its level and vector number on registered outputs.

Software reaches the state through a plain 32-bit register bus with an address, a read strobe and a write strobe. Only the low 8 address bits are decoded. Read data is combinational and valid while the read strobe is high. A write to an offset with no register behind it changes nothing and raises a one-cycle error pulse.

Top module: `prio_intc`

## Requirements
- R1: A source is active when its pending bit or its force bit is 1, its level register is nonzero, and its mask bit is 0. A bit index equals the source number.
- R2: Among active sources, the largest level wins. When levels are equal, the higher source number wins.
- R3: `irq_vector` is the winner's number plus 64 and `irq_level` is the winner's level. With no active source, `irq_vector` is 24 and `irq_level` is 0.
- R4: The level register of source i sits at byte offset 0x40+i. A write stores only wdata[7:0], and a stored zero disables the source. A read returns the level zero-extended.
- R5: Pending bits 63..32 read at offset 0x00 and bits 31..0 read at 0x04. Writes to either offset are ignored and raise no error.
- R6: Mask bits 63..32 are at 0x08 and bits 31..0 at 0x0C. A write replaces only its own half.
- R7: Force bits 63..32 are at 0x10 and bits 31..0 at 0x14. They are readable and writable by halves.
- R8: Offset 0xE0 reads the current `irq_vector` in bits 7..0. A read of any unmapped offset returns 0.
- R9: After reset the mask is all ones, pending, force and all levels are 0, `irq_level` is 0 and `irq_vector` is 24.
- R10: At each clock edge, pending bit i takes the value of `irq_req[i]`.
- R11: `irq_level` and `irq_vector` are registered. They reflect the pending, mask, force and level state that held during the previous cycle.
- R12: A write to an unmapped offset changes no state. `bus_err` is high for exactly the one cycle after that write's clock edge.
- R13: Address bits above bit 7 are ignored by the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_addr | input | 12 | Byte address; only bits 7..0 are decoded |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe; gates bus_rdata |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when bus_rd is low |
| bus_err | output | 1 | One-cycle pulse after a write to an unmapped offset |
| irq_level | output | 8 | Level of the winning source, 0 when none |
| irq_vector | output | 8 | Winning source number plus 64, or 24 when none |

## Verification
On every cycle the assertions check several properties. A fully set mask forces the level to zero one cycle later. A zero level always pairs with the spurious vector, and a live vector stays within 64..127. The outputs do not move unless the pending, mask, force or level state changed in the cycle before. Every error pulse follows a write, and reset leaves the spurious vector and a zero level. Some behaviour can only be shown by the bench's scenarios, which compare each result against a model computed from the requirements. This covers which source wins under level ordering and ties, half-word isolation of mask and force, low-byte-only level writes, address aliasing, and the exact one-cycle update latency.

// File: rtl/irqc_pkg.sv
// Package: shared constants of the prioritized interrupt controller.
// Assumes exactly 64 sources and a 32-bit register bus with byte offsets.
package irqc_pkg;
    localparam int NSRC     = 64;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(NSRC);
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 64;
    localparam int VEC_SPUR = 24;

    localparam logic [7:0] OFS_PEND_HI  = 8'h00;
    localparam logic [7:0] OFS_PEND_LO  = 8'h04;
    localparam logic [7:0] OFS_MASK_HI  = 8'h08;
    localparam logic [7:0] OFS_MASK_LO  = 8'h0C;
    localparam logic [7:0] OFS_FORCE_HI = 8'h10;
    localparam logic [7:0] OFS_FORCE_LO = 8'h14;
    localparam logic [7:0] OFS_VECTOR   = 8'hE0;
    localparam logic [1:0] LVL_WINDOW   = 2'b01;   // offsets 0x40..0x7F
endpackage

// File: rtl/irqc_regs.sv
// Module: register file and bus decode of the interrupt controller.
// Holds pending (sampled request lines), mask, force and per-source levels.
// Assumes the caller passes only the low 8 address bits; reads are
// combinational, and a write to an unmapped offset flags a one-cycle error.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            req,
    input  logic [7:0]                 off,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [VEC_W-1:0]           vec_q,
    output logic [DATA_W-1:0]          rdata,
    output logic                       err,
    output logic [NSRC-1:0]            pend,
    output logic [NSRC-1:0]            mask,
    output logic [NSRC-1:0]            force_q,
    output logic [NSRC-1:0][LVL_W-1:0] lvl
);
    localparam int HALF = DATA_W;

    logic             in_lvl;
    logic             mapped;
    logic [IDX_W-1:0] lidx;

    // Purpose: classify the offset into level window and mapped registers.
    always_comb begin
        in_lvl = (off[7:6] == LVL_WINDOW);
        lidx   = off[IDX_W-1:0];
        mapped = in_lvl || (off == OFS_PEND_HI) || (off == OFS_PEND_LO)
              || (off == OFS_MASK_HI) || (off == OFS_MASK_LO)
              || (off == OFS_FORCE_HI) || (off == OFS_FORCE_LO);
    end

    // Purpose: sample requests and apply bus writes to mask, force and levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            mask    <= '1;
            force_q <= '0;
            lvl     <= '0;
        end else begin
            pend <= req;
            if (wr_en) begin
                if (in_lvl) begin
                    lvl[lidx] <= wdata[LVL_W-1:0];
                end
                case (off)
                    OFS_MASK_HI:  mask[2*HALF-1:HALF]    <= wdata;
                    OFS_MASK_LO:  mask[HALF-1:0]         <= wdata;
                    OFS_FORCE_HI: force_q[2*HALF-1:HALF] <= wdata;
                    OFS_FORCE_LO: force_q[HALF-1:0]      <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Purpose: one-cycle error pulse for writes that hit no register.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= wr_en && !mapped;
    end

    // Purpose: combinational read multiplexer, zero when not reading.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (in_lvl) begin
                rdata = DATA_W'(lvl[lidx]);
            end else begin
                case (off)
                    OFS_PEND_HI:  rdata = pend[2*HALF-1:HALF];
                    OFS_PEND_LO:  rdata = pend[HALF-1:0];
                    OFS_MASK_HI:  rdata = mask[2*HALF-1:HALF];
                    OFS_MASK_LO:  rdata = mask[HALF-1:0];
                    OFS_FORCE_HI: rdata = force_q[2*HALF-1:HALF];
                    OFS_FORCE_LO: rdata = force_q[HALF-1:0];
                    OFS_VECTOR:   rdata = DATA_W'(vec_q);
                    default:      rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Module: combinational priority tree over all sources.
// Picks the active source with the largest level; on equal levels the
// higher index wins. Assumes NSRC is a power of two (heap-ordered tree).
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic [NSRC-1:0]            act,
    input  logic [NSRC-1:0][LVL_W-1:0] lvl,
    output logic                       win_vld,
    output logic [LVL_W-1:0]           win_lvl,
    output logic [IDX_W-1:0]           win_idx
);
    localparam int NODES = 2 * NSRC - 1;
    localparam int LEAF0 = NSRC - 1;

    logic             nv [NODES];
    logic [LVL_W-1:0] nl [NODES];
    logic [IDX_W-1:0] ni [NODES];

    // Purpose: leaves carry each source's activity, level and index.
    for (genvar i = 0; i < NSRC; i++) begin : g_leaf
        assign nv[LEAF0+i] = act[i];
        assign nl[LEAF0+i] = lvl[i];
        assign ni[LEAF0+i] = IDX_W'(i);
    end

    // Purpose: each node keeps the right (higher-index) child unless the
    // left child is valid and strictly stronger.
    for (genvar k = 0; k < LEAF0; k++) begin : g_node
        logic take_r;
        assign take_r = nv[2*k+2] && (!nv[2*k+1] || (nl[2*k+2] >= nl[2*k+1]));
        assign nv[k]  = nv[2*k+1] || nv[2*k+2];
        assign nl[k]  = take_r ? nl[2*k+2] : nl[2*k+1];
        assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
    end

    assign win_vld = nv[0];
    assign win_lvl = nl[0];
    assign win_idx = ni[0];
endmodule

// File: rtl/prio_intc.sv
// Module: prioritized 64-source interrupt controller, top level.
// Combines the register file and the priority tree, and registers the
// level and vector presented to the processor. Assumes a single clock and
// synchronous active-low reset; only the low 8 address bits are decoded.
module prio_intc
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       irq_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [LVL_W-1:0]  irq_level,
    output logic [7:0]        irq_vector
);
    logic [NSRC-1:0]            pend;
    logic [NSRC-1:0]            mask;
    logic [NSRC-1:0]            force_q;
    logic [NSRC-1:0][LVL_W-1:0] lvl;
    logic [NSRC-1:0]            act;
    logic                       win_vld;
    logic [LVL_W-1:0]           win_lvl;
    logic [IDX_W-1:0]           win_idx;
    logic                       unused_addr_hi;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

    irqc_regs #(.LVL_W(LVL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .off     (bus_addr[7:0]),
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .wdata   (bus_wdata),
        .vec_q   (irq_vector),
        .rdata   (bus_rdata),
        .err     (bus_err),
        .pend    (pend),
        .mask    (mask),
        .force_q (force_q),
        .lvl     (lvl)
    );

    // Purpose: per-source activity = requested, enabled by level, unmasked.
    for (genvar i = 0; i < NSRC; i++) begin : g_act
        assign act[i] = (pend[i] || force_q[i]) && (lvl[i] != '0) && !mask[i];
    end

    irqc_arbiter #(.LVL_W(LVL_W)) u_arb (
        .act     (act),
        .lvl     (lvl),
        .win_vld (win_vld),
        .win_lvl (win_lvl),
        .win_idx (win_idx)
    );

    // Purpose: register the winner's level and vector toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= VEC_W'(VEC_SPUR);
        end else if (win_vld) begin
            irq_level  <= win_lvl;
            irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        end else begin
            irq_level  <= '0;
            irq_vector <= VEC_W'(VEC_SPUR);
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Module: assertion checker for prio_intc, attached with bind below.
// Observes the top ports and the register state the top exposes as nets.
module prio_intc_chk
    import irqc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic                       bus_err,
    input logic [LVL_W-1:0]           irq_level,
    input logic [7:0]                 irq_vector,
    input logic [NSRC-1:0]            pend,
    input logic [NSRC-1:0]            mask,
    input logic [NSRC-1:0]            force_q,
    input logic [NSRC-1:0][LVL_W-1:0] lvl
);
    localparam int ST_W = 3 * NSRC + NSRC * LVL_W;

    logic [ST_W-1:0] st;
    logic [ST_W-1:0] prev_st;
    logic            same_q;
    logic [1:0]      cnt;

    assign st = {pend, mask, force_q, lvl};

    // Purpose: track whether the state held still across the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_st <= '0;
            same_q  <= 1'b0;
            cnt     <= '0;
        end else begin
            prev_st <= st;
            same_q  <= (st == prev_st);
            if (cnt != 2'd3) cnt <= cnt + 2'd1;
        end
    end

    a_r1_full_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&mask) |-> (irq_level == '0));

    a_r3_level_vector_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_level == '0) == (irq_vector == 8'(VEC_SPUR)))
        && ((irq_vector == 8'(VEC_SPUR)) || (irq_vector >= 8'd64 && irq_vector < 8'd128)));

    a_r9_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_level == '0 && irq_vector == 8'(VEC_SPUR)));

    a_r11_hold_without_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= 2'd2 && same_q) |-> ($stable(irq_level) && $stable(irq_vector)));

    a_r12_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_wr));
endmodule

bind prio_intc prio_intc_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_err    (bus_err),
    .irq_level  (irq_level),
    .irq_vector (irq_vector),
    .pend       (pend),
    .mask       (mask),
    .force_q    (force_q),
    .lvl        (lvl)
);

// File: tb/prio_intc_tb.sv
// Bench: sweeps sources, levels, ties, masks and force bits of prio_intc
// and compares against a model computed from the requirements.
module prio_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  irq_level;
    logic [7:0]  irq_vector;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] m_mask;
    logic [63:0] m_force;
    logic [7:0]  m_lvl [64];

    always #2 clk = ~clk;

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[7:6] == 2'b01) m_lvl[a[5:0]] = d[7:0];
        case (a[7:0])
            8'h08: m_mask[63:32]  = d;
            8'h0C: m_mask[31:0]   = d;
            8'h10: m_force[63:32] = d;
            8'h14: m_force[31:0]  = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // Model of R1..R3: ascending scan, >= keeps the higher index on ties.
    task automatic expect_out(output logic [7:0] lv, output logic [7:0] vc);
        int best = -1;
        lv = 8'd0;
        for (int i = 0; i < 64; i++) begin
            if ((irq_req[i] || m_force[i]) && m_lvl[i] != 8'd0 && !m_mask[i]
                && m_lvl[i] >= lv) begin
                lv = m_lvl[i];
                best = i;
            end
        end
        vc = (best < 0) ? 8'd24 : 8'(64 + best);
    endtask

    task automatic chk_out(input string rq);
        logic [7:0] lv, vc;
        expect_out(lv, vc);
        chk({rq, " level"}, {24'd0, irq_level}, {24'd0, lv});
        chk({rq, " vector"}, {24'd0, irq_vector}, {24'd0, vc});
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        m_mask = '1;
        m_force = '0;
        for (int i = 0; i < 64; i++) m_lvl[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 level", {24'd0, irq_level}, 32'd0);
        chk("R9 vector", {24'd0, irq_vector}, 32'd24);
        rd(12'h008, d); chk("R9 mask hi", d, 32'hFFFF_FFFF);
        rd(12'h00C, d); chk("R9 mask lo", d, 32'hFFFF_FFFF);
        rd(12'h004, d); chk("R9 pend lo", d, 32'd0);
        rd(12'h014, d); chk("R9 force lo", d, 32'd0);
        rd(12'h07F, d); chk("R9 level reg", d, 32'd0);
        rd(12'h0E0, d); chk("R8 vector reg", d, 32'd24);
        // R1: requests with full mask stay silent
        irq_req = '1; settle(); chk_out("R1 masked");
        irq_req = '0;

        // R4 R6: program distinct levels, unmask all
        for (int i = 0; i < 64; i++) wr(12'h040 + 12'(i), 32'((i % 7) + 1));
        wr(12'h008, 32'd0);
        wr(12'h00C, 32'd0);
        rd(12'h045, d); chk("R4 level readback", d, 32'd6);

        // R3 R10: each source alone
        for (int i = 0; i < 64; i++) begin
            irq_req = 64'd1 << i;
            settle();
            chk_out("R3 single");
            rd(12'h000, d); chk("R10 pend hi", d, irq_req[63:32]);
            rd(12'h004, d); chk("R10 pend lo", d, irq_req[31:0]);
        end

        // R2: ties resolve to highest index, then level beats index
        for (int i = 0; i < 64; i++) wr(12'h040 + 12'(i), 32'd5);
        irq_req = '1; settle(); chk_out("R2 tie all");
        chk("R2 tie vector", {24'd0, irq_vector}, 32'd127);
        wr(12'h04A, 32'd9); settle(); chk_out("R2 level wins");
        wr(12'h068, 32'd9); settle(); chk_out("R2 tie higher");
        chk("R2 tie higher vec", {24'd0, irq_vector}, 32'd104);

        // R6 R11: mask upper half; latency exactly one cycle after write
        wr(12'h008, 32'hFFFF_FFFF);
        chk("R11 still old", {24'd0, irq_vector}, 32'd104);
        @(negedge clk);
        chk_out("R11 updated");
        chk("R6 mask hi vec", {24'd0, irq_vector}, 32'd74);
        rd(12'h00C, d); chk("R6 lo untouched", d, 32'd0);
        rd(12'h008, d); chk("R6 hi readback", d, 32'hFFFF_FFFF);

        // R4: zero level disables; only low byte stored
        wr(12'h04A, 32'h0000_0100); settle(); chk_out("R4 low byte zero");
        rd(12'h04A, d); chk("R4 low byte", d, 32'd0);
        wr(12'h04A, 32'hFFFF_FF03); rd(12'h04A, d); chk("R4 byte only", d, 32'd3);

        // R7: force drives a source with no request
        irq_req = '0;
        wr(12'h014, 32'h0000_0008); settle(); chk_out("R7 force lo");
        chk("R7 force vec", {24'd0, irq_vector}, 32'd67);
        wr(12'h010, 32'h8000_0000); wr(12'h008, 32'd0); settle(); chk_out("R7 force hi");
        rd(12'h010, d); chk("R7 force hi rd", d, 32'h8000_0000);
        rd(12'h014, d); chk("R7 force lo rd", d, 32'h0000_0008);
        wr(12'h010, 32'd0); wr(12'h014, 32'd0);

        // R5: pending writes ignored, no error
        irq_req = 64'h0000_0001_0000_0002; settle();
        wr(12'h000, 32'hFFFF_FFFF);
        chk("R5 no err", {31'd0, bus_err}, 32'd0);
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h000, d); chk("R5 pend hi", d, 32'h0000_0001);
        rd(12'h004, d); chk("R5 pend lo", d, 32'h0000_0002);
        settle(); chk_out("R5 outputs");

        // R12 R8: unmapped write pulses error and changes nothing
        wr(12'h018, 32'hFFFF_FFFF);
        chk("R12 err pulse", {31'd0, bus_err}, 32'd1);
        @(negedge clk);
        chk("R12 err drops", {31'd0, bus_err}, 32'd0);
        wr(12'h0E0, 32'h0000_0000);
        chk("R12 vec write err", {31'd0, bus_err}, 32'd1);
        rd(12'h008, d); chk("R12 mask hi kept", d, 32'd0);
        rd(12'h010, d); chk("R12 force kept", d, 32'd0);
        rd(12'h018, d); chk("R8 unmapped read", d, 32'd0);
        rd(12'h0E0, d); chk("R8 vector read", d, {24'd0, irq_vector});
        settle(); chk_out("R12 outputs");

        // R13: upper address bits ignored
        wr(12'hA0C, 32'hFFFF_FFFD);
        rd(12'h00C, d); chk("R13 alias write", d, 32'hFFFF_FFFD);
        rd(12'h30C, d); chk("R13 alias read", d, 32'hFFFF_FFFD);
        settle(); chk_out("R13 outputs");

        // R1 R2 R3: pseudo-random patterns with frequent ties and zeros
        for (int it = 0; it < 40; it++) begin
            for (int j = 0; j < 4; j++) wr(12'h040 + 12'($urandom % 64), $urandom % 4);
            wr(12'h008, $urandom);
            wr(12'h00C, $urandom);
            wr(12'h014, $urandom & $urandom);
            irq_req = {$urandom, $urandom};
            settle();
            chk_out("R1 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule